// File: doc/BRIEF.md
# Event-Triggered Delayed Pulse Channel

This block is a single trigger output of a timing receiver. An 8-bit event code arrives on every clock cycle. When the code equals the channel's programmed code and the channel is enabled, the match goes through a prescaler. Each match that the prescaler lets through starts a delay countdown. When the countdown expires, the output pulse begins and lasts a programmed number of cycles. A polarity bit sets the idle and active levels of the output.

Each event code reaches the receivers at its own fixed time relative to the beam. To hide that difference, the channel keeps a table with one offset per event code. It subtracts the selected code's offset from the sum of the desired delay and a reference delay. As a result, changing the selected code does not move the pulse relative to the beam. All delay values are written in clock ticks.

Software programs the channel through a write-enable, address and data port. When address bit 8 is set, the write goes to the offset table entry selected by address bits 7:0. When bit 8 is clear, the low bits select a control register:

- 0: control. Bit 0 is enable, bit 1 is polarity, bits 15:8 are the event code.
- 1: prescale.
- 2: desired delay.
- 3: reference delay.
- 4: width.

Top module: `trig_chan`

## Requirements
- R1: After reset, the output sits at its idle level of 0, the overrun count is 0 and the channel is disabled, so no event produces a pulse.
- R2: A pulse starts only for an event whose code equals the programmed code, and only while the enable bit is set. Event code 0 means "no event" and never matches.
- R3: With a prescale value of N ≥ 2, only every Nth match starts a pulse; the first pulse comes on the Nth match. Prescale values of 0 and 1 pass every match.
- R4: If an event is sampled at clock edge e and the effective delay is D ticks, the output becomes active at edge e+D.
- R5: The output stays active for W cycles, where W is the width. A width of 0 gives a 1-cycle pulse.
- R6: When polarity is 1, the output idles high and is driven low while active.
- R7: The effective delay equals desired + reference − offset[selected code]. Each code has its own table entry. The value is rebuilt from registered lookups, so it is settled 2 cycles after a write to the code, a delay or an offset.
- R8: If the computed delay is negative, it saturates to 0 ticks. The output then becomes active at the same edge that samples the event.
- R9: A prescaler-passed match that arrives while a pulse is delayed or active is ignored: the running pulse keeps its timing, and the overrun count rises by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_code | input | 8 | Event code received this cycle (0 means no event) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Bit 8 selects the offset table (bits 7:0 give the code); otherwise this is the register index |
| wr_data | input | 32 | Write data |
| trig_out | output | 1 | Trigger output after polarity |
| ovr_cnt | output | 16 | Count of matches ignored because the channel was busy |

## Verification
The bench drives an event just after a falling edge, so the design samples it at the next rising edge e. It then samples the output at each following falling edge, numbered from 1. The first active sample must be number D+1, and exactly W samples must be active. For D=0 the first active sample is number 1. After any register write, the bench waits three falling edges before sending an event, which covers the two register stages behind the effective delay. The overrun count is read once the pulse has ended, so each check lands in the cycle where its value is already settled.

// File: rtl/trig_chan.sv
module trig_chan #(
  parameter int CODE_W = 8,
  parameter int TIME_W = 32,
  parameter int PRE_W  = 16,
  parameter int OVR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              wr_en,
  input  logic [CODE_W:0]   wr_addr,
  input  logic [TIME_W-1:0] wr_data,
  output logic              trig_out,
  output logic [OVR_W-1:0]  ovr_cnt
);
  localparam int NCODES = 1 << CODE_W;
  localparam int SUM_W  = TIME_W + 2;
  localparam logic [1:0] S_IDLE = 2'd0, S_DLY = 2'd1, S_ACT = 2'd2;

  logic              en_q, pol_q;
  logic [CODE_W-1:0] code_q;
  logic [PRE_W-1:0]  pre_q, pcnt_q;
  logic [TIME_W-1:0] des_q, ref_q, wid_q, off_q, eff_q;
  logic [TIME_W-1:0] off_mem [NCODES];
  logic [1:0]        st_q;
  logic [TIME_W-1:0] dcnt_q, wcnt_q;
  logic [SUM_W-1:0]  sum;
  logic              reg_wr, tab_wr, match, pass;

  assign reg_wr = wr_en && !wr_addr[CODE_W];
  assign tab_wr = wr_en &&  wr_addr[CODE_W];
  assign match  = en_q && (evt_code != '0) && (evt_code == code_q);
  assign pass   = match && ((pre_q <= 1) || (pcnt_q == pre_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pol_q  <= 1'b0;
      code_q <= '0;
      pre_q  <= '0;
      des_q  <= '0;
      ref_q  <= '0;
      wid_q  <= '0;
    end else if (reg_wr) begin
      case (wr_addr[2:0])
        3'd0: begin
          en_q   <= wr_data[0];
          pol_q  <= wr_data[1];
          code_q <= wr_data[8 +: CODE_W];
        end
        3'd1: pre_q <= wr_data[PRE_W-1:0];
        3'd2: des_q <= wr_data;
        3'd3: ref_q <= wr_data;
        3'd4: wid_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tab_wr) off_mem[wr_addr[CODE_W-1:0]] <= wr_data;
  end

  assign sum = {2'b00, des_q} + {2'b00, ref_q} - {2'b00, off_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      eff_q <= '0;
    end else begin
      off_q <= off_mem[code_q];
      if (sum[SUM_W-1])      eff_q <= '0;
      else if (sum[TIME_W])  eff_q <= '1;
      else                   eff_q <= sum[TIME_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!en_q || (reg_wr && wr_addr[2:0] == 3'd1)) begin
      pcnt_q <= '0;
    end else if (match) begin
      pcnt_q <= pass ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
      ovr_cnt <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (pass) begin
          if (eff_q == '0) begin
            st_q   <= S_ACT;
            wcnt_q <= (wid_q == '0) ? TIME_W'(1) : wid_q;
          end else begin
            st_q   <= S_DLY;
            dcnt_q <= eff_q;
          end
        end
        S_DLY: begin
          if (dcnt_q <= TIME_W'(1)) begin
            st_q   <= S_ACT;
            wcnt_q <= (wid_q == '0) ? TIME_W'(1) : wid_q;
          end else begin
            dcnt_q <= dcnt_q - 1'b1;
          end
          if (pass) ovr_cnt <= ovr_cnt + 1'b1;
        end
        S_ACT: begin
          if (wcnt_q <= TIME_W'(1)) st_q <= S_IDLE;
          else                      wcnt_q <= wcnt_q - 1'b1;
          if (pass) ovr_cnt <= ovr_cnt + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign trig_out = (st_q == S_ACT) ^ pol_q;
endmodule

// File: rtl/trig_chan_chk.sv
module trig_chan_chk #(
  parameter int CODE_W = 8,
  parameter int TIME_W = 32,
  parameter int OVR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] evt_code,
  input logic [CODE_W-1:0] code_q,
  input logic              en_q,
  input logic              pol_q,
  input logic [1:0]        st_q,
  input logic [TIME_W-1:0] dcnt_q,
  input logic [TIME_W-1:0] wcnt_q,
  input logic [OVR_W-1:0]  ovr_cnt,
  input logic              trig_out
);
  localparam logic [1:0] S_IDLE = 2'd0, S_DLY = 2'd1, S_ACT = 2'd2;

  AST_START_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && $past(st_q) == S_IDLE) |-> $past(en_q && evt_code != '0 && evt_code == code_q)); // R2
  AST_DLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DLY && dcnt_q > 1) |=> (st_q == S_DLY && dcnt_q == $past(dcnt_q) - 1'b1)); // R4
  AST_WID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ACT) |-> (wcnt_q != '0)); // R5
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pol_q) && $stable(st_q == S_ACT)) |-> $stable(trig_out)); // R6
  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_cnt != $past(ovr_cnt)) |-> (ovr_cnt == $past(ovr_cnt) + 1'b1 && $past(st_q) != S_IDLE)); // R9
endmodule

bind trig_chan trig_chan_chk #(.CODE_W(CODE_W), .TIME_W(TIME_W), .OVR_W(OVR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .code_q(code_q), .en_q(en_q),
  .pol_q(pol_q), .st_q(st_q), .dcnt_q(dcnt_q), .wcnt_q(wcnt_q),
  .ovr_cnt(ovr_cnt), .trig_out(trig_out)
);

// File: tb/sim_trig_chan.sv
`timescale 1ns/1ps
module sim_trig_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_code = '0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        trig_out;
  logic [15:0] ovr_cnt;
  int n_chk = 0, n_bad = 0;
  bit pol_exp = 1'b0;
  bit done = 1'b0;

  trig_chan u0 (.clk(clk), .rst_n(rst_n), .evt_code(evt_code), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .trig_out(trig_out), .ovr_cnt(ovr_cnt));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ctrl(input bit en, input bit pol, input logic [7:0] c);
    wr(9'd0, {16'd0, c, 6'd0, pol, en});
    pol_exp = pol;
  endtask

  task automatic shoot(input logic [7:0] c, input int len, output int first, output int cnt);
    @(negedge clk); evt_code = c; first = -1; cnt = 0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk); evt_code = '0;
      if (trig_out ^ pol_exp) begin
        if (first < 0) first = k;
        cnt++;
      end
    end
  endtask

  task automatic t_reset;
    int f, c;
    chk(trig_out == 1'b0, "R1 idle output", int'(trig_out), 0);
    chk(ovr_cnt == 0, "R1 overrun zero", int'(ovr_cnt), 0);
    wr(9'd4, 32'd3);
    wr(9'h121, 32'd0);
    wr({1'b0, 8'd0} | 9'd0, 32'h0000_2100);
    pol_exp = 1'b0;
    shoot(8'h21, 20, f, c);
    chk(c == 0, "R1 disabled after reset, no pulse", c, 0);
  endtask

  task automatic t_basic;
    int f, c;
    wr(9'd2, 32'd5); wr(9'd3, 32'd3); wr(9'h121, 32'd2); wr(9'd4, 32'd4);
    ctrl(1'b1, 1'b0, 8'h21);
    shoot(8'h21, 30, f, c);
    chk(f == 7, "R4 R7 first active sample", f, 7);
    chk(c == 4, "R5 width cycles", c, 4);
    shoot(8'h22, 30, f, c);
    chk(c == 0, "R2 other code ignored", c, 0);
    ctrl(1'b0, 1'b0, 8'h21);
    shoot(8'h21, 30, f, c);
    chk(c == 0, "R2 disabled ignores match", c, 0);
    ctrl(1'b1, 1'b0, 8'h00);
    shoot(8'h00, 30, f, c);
    chk(c == 0, "R2 code zero never fires", c, 0);
  endtask

  task automatic t_code_swap;
    int f, c;
    wr(9'h140, 32'd5);
    ctrl(1'b1, 1'b0, 8'h40);
    shoot(8'h40, 30, f, c);
    chk(f == 4, "R7 per-code offset applied", f, 4);
    ctrl(1'b1, 1'b0, 8'h21);
    shoot(8'h21, 30, f, c);
    chk(f == 7, "R7 recomputed after code change", f, 7);
  endtask

  task automatic t_prescale;
    int f, c, hits;
    wr(9'd1, 32'd3);
    ctrl(1'b1, 1'b0, 8'h21);
    hits = 0;
    for (int i = 1; i <= 6; i++) begin
      shoot(8'h21, 20, f, c);
      if (c > 0) hits++;
      if (i == 2) chk(hits == 0, "R3 no pulse before third match", hits, 0);
      if (i == 3) chk(hits == 1, "R3 pulse on third match", hits, 1);
    end
    chk(hits == 2, "R3 prescale 3 over six matches", hits, 2);
    wr(9'd1, 32'd0);
    hits = 0;
    for (int i = 0; i < 3; i++) begin
      shoot(8'h21, 20, f, c);
      if (c > 0) hits++;
    end
    chk(hits == 3, "R3 prescale 0 passes all", hits, 3);
    wr(9'd1, 32'd1);
    shoot(8'h21, 20, f, c);
    chk(c == 4, "R3 prescale 1 passes", c, 4);
  endtask

  task automatic t_edges;
    int f, c;
    wr(9'h121, 32'd100);
    shoot(8'h21, 20, f, c);
    chk(f == 1, "R8 negative delay saturates", f, 1);
    wr(9'h121, 32'd8);
    shoot(8'h21, 20, f, c);
    chk(f == 1, "R8 exact zero delay", f, 1);
    wr(9'h121, 32'd2);
    wr(9'd4, 32'd0);
    shoot(8'h21, 30, f, c);
    chk(c == 1, "R5 width zero gives one cycle", c, 1);
    wr(9'd4, 32'd4);
    ctrl(1'b1, 1'b1, 8'h21);
    chk(trig_out == 1'b1, "R6 inverted idle level", int'(trig_out), 1);
    shoot(8'h21, 30, f, c);
    chk(f == 7 && c == 4, "R6 inverted pulse timing", f * 100 + c, 704);
    ctrl(1'b1, 1'b0, 8'h21);
  endtask

  task automatic t_overrun;
    int f, c, o0;
    wr(9'd2, 32'd9);
    o0 = int'(ovr_cnt);
    @(negedge clk); evt_code = 8'h21; f = -1; c = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      evt_code = (k == 3 || k == 13) ? 8'h21 : 8'h00;
      if (trig_out) begin
        if (f < 0) f = k;
        c++;
      end
    end
    chk(f == 11, "R9 running pulse keeps timing", f, 11);
    chk(c == 4, "R9 single pulse only", c, 4);
    chk(int'(ovr_cnt) == o0 + 2, "R9 overrun count", int'(ovr_cnt), o0 + 2);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_code_swap();
    t_prescale();
    t_edges();
    t_overrun();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule